// File: doc/BRIEF.md
# Command-Decoded Serial Control Slave

This block is the serial control port of a dual-channel low-side switch. A host reaches it over a four-wire SPI bus made up of an active-low select, a clock, a data input and a data output. Every frame is eight bits: the top three bits choose an operation and the lower five bits carry its argument. When the select falls, the port loads the current diagnosis byte into its shift register. That byte then goes out on the data output, most significant bit first, while the new command comes in. When the select rises, the port decodes the command and commits it. Accepted commands also produce a one-cycle pulse that the diagnosis logic uses to clear its latched flags.

Incoming bits pass straight through the shift register, so several ports can be chained. Only the last eight bits clocked in before the select rises are decoded. The port holds three setting registers: an output settings word, an input/sense settings word and a two-bit channel enable. It also handles a sleep request and a wake request. In sleep, only the wake command is accepted. After a wake, the port stays in a waking state for a set number of clock cycles before it returns to normal operation. All bus pins are sampled on the system clock, so the bus clock must run well below that clock.

Top module: `diag_spi_slave`

## Requirements
- R1: After reset, out_cfg_o, io_cfg_o and ch_en_o are zero, sleep_o is low, so_oe_o is low and diag_clr_o is low.
- R2: While cs_n is high, so_oe_o is low and activity on sclk and si changes no register and produces no diag_clr_o pulse.
- R3: When cs_n falls, diag_i is captured. so_o first presents bit 7 of that capture, then moves to the next bit after each rising sclk edge that follows a falling edge. si is sampled on the falling edges of sclk.
- R4: A frame is acted on only if the number of falling sclk edges while cs_n was low is a nonzero multiple of 8. Any other frame has no effect.
- R5: The operation code is frame bits 7:5 and the argument is bits 4:0. Code 010 loads the argument into out_cfg_o, and code 011 loads it into io_cfg_o.
- R6: Code 111 loads frame bit 4 into ch_en_o[1] and frame bit 3 into ch_en_o[0].
- R7: Code 100 clears out_cfg_o, io_cfg_o and ch_en_o.
- R8: Code 000 changes no register and gives no clear pulse. Code 001 changes no register but does give a clear pulse.
- R9: Each accepted non-null frame raises diag_clr_o for exactly one clock cycle, one cycle after the cycle in which cs_n is seen high.
- R10: Code 101 sets sleep_o and clears ch_en_o, while out_cfg_o and io_cfg_o keep their values. While sleep_o is high, every code except 110 is rejected, with no register change and no clear pulse.
- R11: Code 110 given in sleep keeps sleep_o high for exactly WAKE_CYCLES cycles after the clear pulse edge, with ch_en_o held at zero, and then drops sleep_o.
- R12: In a chain frame of 16 bits, only the last 8 bits received are decoded. so_o sends out the captured diagnosis byte followed by the first 8 bits received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Bus clock, idle low |
| si | input | 1 | Serial data in |
| diag_i | input | 8 | Diagnosis byte captured at frame start |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Drive enable for so_o; the pin is high impedance when this is low |
| out_cfg_o | output | 5 | Output settings: [4] ch2 limit mode, [3] ch1 limit mode, [2] restart mode, [1:0] per-channel slope |
| io_cfg_o | output | 5 | Input/sense settings: [4] fault pin mode, [3:2] input combine mode, [1:0] sense select |
| ch_en_o | output | 2 | Channel enables from the on/off command |
| sleep_o | output | 1 | High while asleep or waking |
| diag_clr_o | output | 1 | One-cycle pulse that clears the diagnosis flags |

## Verification
The bench targets frames whose length is not a multiple of eight: 7 bits, 9 bits, and a select pulse with no clock edges at all. A port that counted badly would commit a truncated or skewed command, or would clear diagnosis it should have left alone. Sleep is tested with a setting write that should be rejected and with the exact length of the wake window. A port that was off by one there would release the channels a cycle early, or would accept writes while asleep. Chained 16-bit frames check that the output stream carries the diagnosis byte and then the first received byte, which exposes a port that shifts on the wrong edge or decodes the first byte instead of the last. Null and read-only frames separate "no write" from "no clear".

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int FRAME_W = 8;
  localparam int OP_W    = 3;
  localparam int ARG_W   = FRAME_W - OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_NULL   = 3'd0,
    OP_READ   = 3'd1,
    OP_OUTCFG = 3'd2,
    OP_IOCFG  = 3'd3,
    OP_RESET  = 3'd4,
    OP_SLEEP  = 3'd5,
    OP_WAKE   = 3'd6,
    OP_SWITCH = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    PWR_RUN    = 2'd0,
    PWR_SLEEP  = 2'd1,
    PWR_WAKING = 2'd2
  } pwr_e;

  function automatic op_e frame_op(input logic [FRAME_W-1:0] f);
    return op_e'(f[FRAME_W-1 -: OP_W]);
  endfunction

  function automatic logic [ARG_W-1:0] frame_arg(input logic [FRAME_W-1:0] f);
    return f[ARG_W-1:0];
  endfunction

  // A non-null op is taken when awake; only the wake op is taken otherwise.
  function automatic logic op_allowed(input op_e op, input logic asleep);
    return (op != OP_NULL) && (!asleep || (op == OP_WAKE));
  endfunction
endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_cmd_pkg::*;
#(
  parameter int BITS = FRAME_W,
  localparam int CNT_W = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            si,
  input  logic [BITS-1:0] diag_i,
  output logic            so_o,
  output logic            so_oe_o,
  output logic [BITS-1:0] frame_o,
  output logic            frame_done_o
);
  logic            cs_q, sclk_q, so_q, oe_q, byte_seen_q;
  logic [BITS-1:0] shreg_q;
  logic [CNT_W-1:0] bit_cnt_q;

  // Named events for the assertions and the decoder.
  logic cs_fall, cs_rise, in_frame, sclk_fall, sclk_rise, cnt_last;
  assign cs_fall   = cs_q & ~cs_n;
  assign cs_rise   = ~cs_q & cs_n;
  assign in_frame  = ~cs_q & ~cs_n;
  assign sclk_fall = in_frame & sclk_q & ~sclk;
  assign sclk_rise = in_frame & ~sclk_q & sclk;
  assign cnt_last  = (bit_cnt_q == CNT_W'(BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q        <= 1'b1;
      sclk_q      <= 1'b0;
      so_q        <= 1'b0;
      oe_q        <= 1'b0;
      byte_seen_q <= 1'b0;
      shreg_q     <= '0;
      bit_cnt_q   <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      oe_q   <= ~cs_n;
      if (cs_fall) begin
        shreg_q     <= diag_i;
        so_q        <= diag_i[BITS-1];
        bit_cnt_q   <= '0;
        byte_seen_q <= 1'b0;
      end else if (sclk_fall) begin
        shreg_q   <= {shreg_q[BITS-2:0], si};
        bit_cnt_q <= cnt_last ? '0 : bit_cnt_q + 1'b1;
        if (cnt_last) byte_seen_q <= 1'b1;
      end else if (sclk_rise) begin
        so_q <= shreg_q[BITS-1];
      end
    end
  end

  assign so_o         = so_q;
  assign so_oe_o      = oe_q;
  assign frame_o      = shreg_q;
  assign frame_done_o = cs_rise & byte_seen_q & (bit_cnt_q == '0);

  AST_CAPTURE_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (shreg_q == $past(diag_i)));                       // R3
  AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !so_oe_o);                            // R2
  AST_DONE_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (cs_n && !$past(cs_n)));                       // R4
endmodule

// File: rtl/spi_wake_timer.sv
module spi_wake_timer #(
  parameter int WAKE_CYCLES = 16,
  localparam int CNT_W = $clog2(WAKE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_W'(WAKE_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == CNT_W'(1));

  AST_WAKE_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));  // R11
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic             wake_done_i,
  output logic [ARG_W-1:0] out_cfg_o,
  output logic [ARG_W-1:0] io_cfg_o,
  output logic [1:0]       onoff_o,
  output pwr_e             pwr_o,
  output logic             wake_start_o,
  output logic             diag_clr_o
);
  logic [ARG_W-1:0] out_cfg_q, io_cfg_q, arg;
  logic [1:0]       onoff_q;
  pwr_e             pwr_q;
  logic             clr_q, asleep, accept;
  op_e              op;

  assign op           = frame_op(frame_i);
  assign arg          = frame_arg(frame_i);
  assign asleep       = (pwr_q != PWR_RUN);
  assign accept       = commit_i & op_allowed(op, asleep);
  assign wake_start_o = accept & (op == OP_WAKE) & (pwr_q == PWR_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cfg_q <= '0;
      io_cfg_q  <= '0;
      onoff_q   <= '0;
      pwr_q     <= PWR_RUN;
      clr_q     <= 1'b0;
    end else begin
      clr_q <= accept;
      if (pwr_q == PWR_WAKING && wake_done_i) pwr_q <= PWR_RUN;
      if (accept) begin
        unique case (op)
          OP_OUTCFG: out_cfg_q <= arg;
          OP_IOCFG:  io_cfg_q  <= arg;
          OP_RESET: begin
            out_cfg_q <= '0;
            io_cfg_q  <= '0;
            onoff_q   <= '0;
          end
          OP_SLEEP: begin
            onoff_q <= '0;
            pwr_q   <= PWR_SLEEP;
          end
          OP_WAKE:   if (pwr_q == PWR_SLEEP) pwr_q <= PWR_WAKING;
          OP_SWITCH: onoff_q <= arg[ARG_W-1 -: 2];
          default: ;
        endcase
      end
    end
  end

  assign out_cfg_o  = out_cfg_q;
  assign io_cfg_o   = io_cfg_q;
  assign onoff_o    = onoff_q;
  assign pwr_o      = pwr_q;
  assign diag_clr_o = clr_q;

  AST_OFF_WHILE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q != PWR_RUN) |-> (onoff_q == 2'b00));                     // R10
  AST_WRITE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(out_cfg_q) && $stable(io_cfg_q)));       // R4
  AST_CLEAR_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> $past(commit_i));                                     // R9
  AST_WAKE_FROM_WAKING: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_q) != PWR_RUN && pwr_q == PWR_RUN) |-> $past(pwr_q == PWR_WAKING)); // R11
endmodule

// File: rtl/diag_spi_slave.sv
module diag_spi_slave
  import spi_cmd_pkg::*;
#(
  parameter int WAKE_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         si,
  input  logic [7:0]   diag_i,
  output logic         so_o,
  output logic         so_oe_o,
  output logic [4:0]   out_cfg_o,
  output logic [4:0]   io_cfg_o,
  output logic [1:0]   ch_en_o,
  output logic         sleep_o,
  output logic         diag_clr_o
);
  logic [FRAME_W-1:0] frame;
  logic               frame_done, wake_start, wake_done;
  pwr_e               pwr;

  spi_frame_shifter #(.BITS(FRAME_W)) u_shift (
    .clk, .rst_n, .cs_n, .sclk, .si, .diag_i,
    .so_o, .so_oe_o,
    .frame_o(frame), .frame_done_o(frame_done)
  );

  spi_cmd_regs u_regs (
    .clk, .rst_n,
    .commit_i(frame_done), .frame_i(frame), .wake_done_i(wake_done),
    .out_cfg_o, .io_cfg_o, .onoff_o(ch_en_o), .pwr_o(pwr),
    .wake_start_o(wake_start), .diag_clr_o
  );

  spi_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk, .rst_n, .start_i(wake_start), .done_o(wake_done)
  );

  assign sleep_o = (pwr != PWR_RUN);
endmodule

// File: tb/diag_spi_slave_bench.sv
module diag_spi_slave_bench;
  localparam int W = 12;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, si = 0;
  logic [7:0] diag = 8'h00;
  logic so, so_oe, sleep, clr;
  logic [4:0] out_cfg, io_cfg;
  logic [1:0] ch_en;

  always #5 clk = ~clk;

  diag_spi_slave #(.WAKE_CYCLES(W)) u_diag_spi_slave (
    .clk, .rst_n, .cs_n, .sclk, .si, .diag_i(diag),
    .so_o(so), .so_oe_o(so_oe), .out_cfg_o(out_cfg), .io_cfg_o(io_cfg),
    .ch_en_o(ch_en), .sleep_o(sleep), .diag_clr_o(clr)
  );

  int tests = 0, fails = 0, clr_count = 0, cyc = 0, t_clr = 0, t_wake = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: queue of received bits, integer counts.
  bit m_cs_prev = 1, m_sclk_prev = 0, m_so = 0, m_oe = 0, m_clr = 0;
  bit m_rx[$];
  bit [7:0] m_cap = 0;
  int m_pos = 0, m_falls = 0, m_pwr = 0, m_wake_left = 0;
  logic [4:0] m_out = 0, m_io = 0;
  logic [1:0] m_on = 0;
  bit prev_sleep = 0;

  function automatic bit [7:0] last_byte();
    bit [7:0] b = 0;
    for (int i = 0; i < 8; i++) b[7-i] = m_rx[m_rx.size()-8+i];
    return b;
  endfunction

  function automatic bit out_bit(input int k);
    if (k < 8) return m_cap[7-k];
    return m_rx[k-8];
  endfunction

  always @(posedge clk) begin
    int old_pwr;
    bit [7:0] f;
    cyc++;
    if (!rst_n) begin
      m_cs_prev = 1; m_sclk_prev = 0; m_so = 0; m_oe = 0; m_clr = 0;
      m_out = 0; m_io = 0; m_on = 0; m_pwr = 0; m_wake_left = 0; m_falls = 0;
    end else begin
      old_pwr = m_pwr;
      m_clr = 0;
      if (m_cs_prev && !cs_n) begin
        m_cap = diag; m_rx.delete(); m_falls = 0; m_pos = 0; m_so = diag[7];
      end else if (!m_cs_prev && !cs_n) begin
        if (m_sclk_prev && !sclk) begin m_rx.push_back(si); m_falls++; end
        else if (!m_sclk_prev && sclk && m_falls > m_pos) begin
          m_pos = m_falls; m_so = out_bit(m_pos);
        end
      end else if (!m_cs_prev && cs_n && m_falls > 0 && m_falls % 8 == 0) begin
        f = last_byte();
        if (f[7:5] != 0 && (old_pwr == 0 || f[7:5] == 6)) begin
          m_clr = 1;
          case (f[7:5])
            2: m_out = f[4:0];
            3: m_io = f[4:0];
            4: begin m_out = 0; m_io = 0; m_on = 0; end
            5: begin m_on = 0; m_pwr = 1; end
            6: if (old_pwr == 1) begin m_pwr = 2; m_wake_left = W + 1; end
            7: m_on = f[4:3];
            default: ;
          endcase
        end
      end
      if (m_pwr == 2) begin
        m_wake_left--;
        if (m_wake_left == 0) m_pwr = 0;
      end
      m_oe = !cs_n;
    end
    m_cs_prev = cs_n; m_sclk_prev = sclk;
    #2;
    if (rst_n) begin
      check(so_oe === m_oe, "R2", "so_oe vs model", so_oe, m_oe);
      if (m_oe) check(so === m_so, "R3", "so vs model", so, m_so);
      check(out_cfg === m_out, "R5", "out_cfg vs model", out_cfg, m_out);
      check(io_cfg === m_io, "R5", "io_cfg vs model", io_cfg, m_io);
      check(ch_en === m_on, "R6", "ch_en vs model", ch_en, m_on);
      check(sleep === (m_pwr != 0), "R10", "sleep vs model", sleep, m_pwr != 0);
      check(clr === m_clr, "R9", "diag_clr vs model", clr, m_clr);
      if (clr) begin clr_count++; t_clr = cyc; end
      if (prev_sleep && !sleep) t_wake = cyc;
      prev_sleep = sleep;
    end
  end

  logic [31:0] so_cap;

  task automatic frame(input logic [31:0] data, input int n);
    so_cap = 0;
    @(negedge clk) cs_n = 0;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1;
      repeat (2) @(negedge clk);
      so_cap = {so_cap[30:0], so};
      si = data[i];
      @(negedge clk) sclk = 0;
      repeat (2) @(negedge clk);
    end
    cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(out_cfg == 0 && io_cfg == 0 && ch_en == 0, "R1", "regs after reset",
          {out_cfg, io_cfg, ch_en}, 0);
    check(!sleep && !so_oe && !clr, "R1", "flags after reset", {sleep, so_oe, clr}, 0);

    // R2: clocking with select high
    c0 = clr_count;
    for (int i = 0; i < 20; i++) begin @(negedge clk) begin sclk = ~sclk; si = i[1]; end end
    sclk = 0;
    repeat (3) @(negedge clk);
    check(!so_oe && clr_count == c0 && out_cfg == 0, "R2", "ignored while deselected",
          {so_oe, out_cfg}, 0);

    diag = 8'hA5;
    frame({3'b010, 5'b10110}, 8);
    check(so_cap[7:0] == 8'hA5, "R3", "diag shifted out", so_cap[7:0], 8'hA5);
    check(out_cfg == 5'b10110, "R5", "out_cfg write", out_cfg, 5'b10110);
    check(clr_count == c0 + 1, "R9", "one clear pulse", clr_count, c0 + 1);
    diag = 8'h3C;
    frame({3'b011, 5'b01101}, 8);
    check(io_cfg == 5'b01101 && so_cap[7:0] == 8'h3C, "R5", "io_cfg write",
          {io_cfg, so_cap[7:0]}, {5'b01101, 8'h3C});
    frame({3'b111, 5'b10000}, 8);
    check(ch_en == 2'b10, "R6", "ch2 on", ch_en, 2'b10);
    frame({3'b111, 5'b01000}, 8);
    check(ch_en == 2'b01, "R6", "ch1 on", ch_en, 2'b01);

    c0 = clr_count;
    frame({3'b000, 5'b11111}, 8);
    check(out_cfg == 5'b10110 && clr_count == c0, "R8", "null frame",
          {out_cfg, clr_count[7:0]}, {5'b10110, c0[7:0]});
    frame({3'b001, 5'b00000}, 8);
    check(out_cfg == 5'b10110 && io_cfg == 5'b01101 && clr_count == c0 + 1, "R8",
          "read frame clears only", clr_count, c0 + 1);

    c0 = clr_count;
    frame({3'b010, 5'b00001}, 7);
    frame({1'b0, 3'b010, 5'b00001}, 9);
    frame(0, 0);
    check(out_cfg == 5'b10110 && clr_count == c0, "R4", "bad length frames dropped",
          {out_cfg, clr_count[7:0]}, {5'b10110, c0[7:0]});

    diag = 8'h5A;
    frame({3'b010, 5'b00011, 3'b011, 5'b00111}, 16);
    check(io_cfg == 5'b00111 && out_cfg == 5'b10110, "R12", "last byte decoded",
          {out_cfg, io_cfg}, {5'b10110, 5'b00111});
    check(so_cap[15:0] == {8'h5A, 3'b010, 5'b00011}, "R12", "chain output",
          so_cap[15:0], {8'h5A, 3'b010, 5'b00011});

    frame({3'b100, 5'b11111}, 8);
    check(out_cfg == 0 && io_cfg == 0 && ch_en == 0, "R7", "reset command",
          {out_cfg, io_cfg, ch_en}, 0);

    frame({3'b010, 5'b01010}, 8);
    frame({3'b111, 5'b11000}, 8);
    frame({3'b101, 5'b00000}, 8);
    check(sleep && ch_en == 0 && out_cfg == 5'b01010, "R10", "sleep entry",
          {sleep, ch_en, out_cfg}, {1'b1, 2'b00, 5'b01010});
    c0 = clr_count;
    frame({3'b010, 5'b11111}, 8);
    frame({3'b111, 5'b11000}, 8);
    check(out_cfg == 5'b01010 && ch_en == 0 && clr_count == c0, "R10", "rejected in sleep",
          {out_cfg, ch_en, clr_count[7:0]}, {5'b01010, 2'b00, c0[7:0]});

    frame({3'b110, 5'b00000}, 8);
    check(sleep && ch_en == 0, "R11", "still waking", {sleep, ch_en}, 3'b100);
    repeat (W + 4) @(negedge clk);
    check(!sleep && t_wake - t_clr == W, "R11", "wake delay", t_wake - t_clr, W);
    frame({3'b111, 5'b11000}, 8);
    check(ch_en == 2'b11, "R11", "writes after wake", ch_en, 2'b11);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule